// File: doc/BRIEF.md
# Sector ECC Syndrome Decoder and Corrector

This block compares the three-byte check code read back from flash with the code recomputed over the same 512-byte sector. It reports whether the sector is clean, holds one flipped data bit that can be repaired, holds a fault in the check code itself, or is beyond repair. When a data bit can be repaired, the block gives the byte address inside the sector, the bit index inside that byte, and an 8-bit XOR mask. The caller applies the mask to that byte of its own sector buffer.

Each code first goes into a fixed 24-bit ascending order. The two ordered codes are then XORed into a syndrome. The syndrome is read as twelve bit pairs. When every pair holds a set bit, the odd member of each pair gives one bit of the location. The three lowest pairs give the bit index and the nine upper pairs give the byte address. A start strobe launches one evaluation. One clock later the registered result appears together with a single-cycle done pulse.

Top module: `ecc_syndrome_fix`

## Requirements
- R1: While rst_n is low, done, status, fix_byte, fix_bit and fix_mask are all zero.
- R2: A start strobe in one cycle makes done high in the next cycle only. done is never high unless start was high in the cycle before.
- R3: When code_stored equals code_fresh, status is 2'b00 (clean), and fix_byte, fix_bit and fix_mask are zero.
- R4: Each code holds byte0 in bits [7:0], byte1 in [15:8] and byte2 in [23:16]. It is ordered as {byte2[1:0], byte1, byte0, byte2[7:2]}, so raw bit j moves to position (j+6) mod 24.
- R5: The syndrome is the XOR of the two ordered codes. When every pair (2k, 2k+1), k = 0..11, has at least one bit set, status is 2'b01 (data bit repairable).
- R6: For a repairable result, fix_bit bit k equals syndrome bit 2k+1, for k = 0..2.
- R7: For a repairable result, fix_byte bit k equals syndrome bit 2k+7, for k = 0..8.
- R8: For a repairable result, fix_mask has exactly the bit fix_bit set. For any other result it is zero.
- R9: When the two codes differ in exactly one bit, status is 2'b10 (check-code fault), and fix_byte, fix_bit and fix_mask are zero.
- R10: Any other nonzero difference gives status 2'b11 (unrepairable), and fix_byte, fix_bit and fix_mask are zero.
- R11: In a cycle without start, status, fix_byte, fix_bit and fix_mask keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Evaluate the two codes presented this cycle |
| code_stored | input | 24 | Check code read back from flash |
| code_fresh | input | 24 | Check code recomputed over the sector |
| done | output | 1 | One-cycle pulse, result valid |
| status | output | 2 | 00 clean, 01 repairable, 10 code fault, 11 unrepairable |
| fix_byte | output | 9 | Byte address within the sector to repair |
| fix_bit | output | 3 | Bit index within that byte |
| fix_mask | output | 8 | XOR mask for that byte |

## Verification
The bench builds the block with its package defaults: a 3-bit bit index and a 9-bit byte address, which make a 24-bit syndrome of twelve pairs. At that size, all 24 single-bit check-code faults can be run exhaustively, and so can every one of the eight bit indices. The byte address is driven to both ends, 0 and 511, and to alternating patterns. The bench also applies an all-ones syndrome, where every pair is doubly set, and differences that leave exactly one pair empty.

// File: rtl/ecc_fix_pkg.sv
package ecc_fix_pkg;
  localparam int BIT_W  = 3;
  localparam int ADDR_W = 9;
  localparam int PAIRS  = BIT_W + ADDR_W;
  localparam int SYN_W  = 2 * PAIRS;
  localparam int MASK_W = 1 << BIT_W;
  localparam int ROT    = 6;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_CODE  = 2'b10,
    ST_FATAL = 2'b11
  } fix_status_e;

  // Pair-low-bit select: one bit per pair at even positions.
  function automatic logic [SYN_W-1:0] even_sel();
    logic [SYN_W-1:0] m;
    m = '0;
    for (int k = 0; k < PAIRS; k++) m[2*k] = 1'b1;
    return m;
  endfunction

  // Byte2 low bits land on top, byte2 high bits at the bottom.
  function automatic logic [SYN_W-1:0] order_code(input logic [SYN_W-1:0] c);
    return {c[SYN_W-ROT-1:0], c[SYN_W-1:SYN_W-ROT]};
  endfunction

  function automatic logic pairs_covered(input logic [SYN_W-1:0] s);
    return ((s | (s >> 1)) & even_sel()) == even_sel();
  endfunction
endpackage

// File: rtl/ecc_code_order.sv
module ecc_code_order
  import ecc_fix_pkg::*;
(
  input  logic [SYN_W-1:0] code_raw,
  output logic [SYN_W-1:0] code_ord
);
  assign code_ord = order_code(code_raw);
endmodule

// File: rtl/ecc_syn_classify.sv
module ecc_syn_classify
  import ecc_fix_pkg::*;
(
  input  logic [SYN_W-1:0] syn,
  output logic             syn_zero,
  output logic             syn_cover,
  output logic             syn_single,
  output fix_status_e      cls
);
  assign syn_zero   = (syn == '0);
  assign syn_cover  = pairs_covered(syn);
  assign syn_single = ($countones(syn) == 1);

  always_comb begin
    if (syn_zero)        cls = ST_CLEAN;
    else if (syn_cover)  cls = ST_FIXED;
    else if (syn_single) cls = ST_CODE;
    else                 cls = ST_FATAL;
  end
endmodule

// File: rtl/ecc_syn_locate.sv
module ecc_syn_locate
  import ecc_fix_pkg::*;
(
  input  logic [PAIRS-1:0]  syn_odd,
  input  logic              fixable,
  output logic [ADDR_W-1:0] loc_byte,
  output logic [BIT_W-1:0]  loc_bit,
  output logic [MASK_W-1:0] loc_mask
);
  assign loc_bit  = fixable ? syn_odd[BIT_W-1:0] : '0;
  assign loc_byte = fixable ? syn_odd[PAIRS-1:BIT_W] : '0;

  for (genvar i = 0; i < MASK_W; i++) begin : g_mask
    assign loc_mask[i] = fixable && (loc_bit == BIT_W'(i));
  end
endmodule

// File: rtl/ecc_syndrome_fix.sv
module ecc_syndrome_fix
  import ecc_fix_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] code_stored,
  input  logic [23:0] code_fresh,
  output logic        done,
  output logic [1:0]  status,
  output logic [8:0]  fix_byte,
  output logic [2:0]  fix_bit,
  output logic [7:0]  fix_mask
);
  logic [SYN_W-1:0]  ord_stored, ord_fresh, syndrome;
  logic [PAIRS-1:0]  syn_odd;
  logic              syn_zero, syn_cover, syn_single;
  fix_status_e       cls;
  logic [ADDR_W-1:0] loc_byte;
  logic [BIT_W-1:0]  loc_bit;
  logic [MASK_W-1:0] loc_mask;

  ecc_code_order u_ord_s (.code_raw(code_stored), .code_ord(ord_stored));
  ecc_code_order u_ord_f (.code_raw(code_fresh),  .code_ord(ord_fresh));

  assign syndrome = ord_stored ^ ord_fresh;

  for (genvar k = 0; k < PAIRS; k++) begin : g_odd
    assign syn_odd[k] = syndrome[2*k+1];
  end

  ecc_syn_classify u_cls (
    .syn(syndrome), .syn_zero(syn_zero), .syn_cover(syn_cover),
    .syn_single(syn_single), .cls(cls)
  );

  ecc_syn_locate u_loc (
    .syn_odd(syn_odd), .fixable(cls == ST_FIXED),
    .loc_byte(loc_byte), .loc_bit(loc_bit), .loc_mask(loc_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done     <= 1'b0;
      status   <= ST_CLEAN;
      fix_byte <= '0;
      fix_bit  <= '0;
      fix_mask <= '0;
    end else begin
      done <= start;
      if (start) begin
        status   <= cls;
        fix_byte <= loc_byte;
        fix_bit  <= loc_bit;
        fix_mask <= loc_mask;
      end
    end
  end
endmodule

// File: rtl/ecc_fix_checker.sv
module ecc_fix_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic [23:0] code_stored,
  input logic [23:0] code_fresh,
  input logic        done,
  input logic [1:0]  status,
  input logic [8:0]  fix_byte,
  input logic [2:0]  fix_bit,
  input logic [7:0]  fix_mask,
  input logic        syn_cover
);
  p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done);
  p_done_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start));
  p_clean_equal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((status == 2'b00) == $past(code_stored == code_fresh)));
  p_cover_fixed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((status == 2'b01) == $past(syn_cover)));
  p_mask_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fix_mask));
  p_mask_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 2'b01) |-> ($countones(fix_mask) == 1 && fix_mask[fix_bit]));
  p_code_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 2'b10) |-> $past($countones(code_stored ^ code_fresh) == 1));
  p_quiet_loc_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status != 2'b01) |-> (fix_mask == 0 && fix_byte == 0 && fix_bit == 0));
  p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(status) && $stable(fix_byte) && $stable(fix_bit) && $stable(fix_mask)));
endmodule

bind ecc_syndrome_fix ecc_fix_checker u_chk (
  .clk(clk), .rst_n(rst_n), .start(start),
  .code_stored(code_stored), .code_fresh(code_fresh),
  .done(done), .status(status), .fix_byte(fix_byte),
  .fix_bit(fix_bit), .fix_mask(fix_mask), .syn_cover(syn_cover)
);

// File: tb/test_ecc_syndrome_fix.sv
module test_ecc_syndrome_fix;
  localparam int CLK_NS = 10;

  typedef struct packed {
    logic [1:0] st;
    logic [8:0] byt;
    logic [2:0] bt;
    logic [7:0] msk;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [23:0] code_stored = '0, code_fresh = '0;
  logic done;
  logic [1:0] status;
  logic [8:0] fix_byte;
  logic [2:0] fix_bit;
  logic [7:0] fix_mask;

  int checks = 0, bad = 0;
  exp_t exp_q[$];
  string tag_q[$];
  exp_t last_exp;

  always #(CLK_NS/2) clk = ~clk;

  ecc_syndrome_fix i_ecc_syndrome_fix (
    .clk(clk), .rst_n(rst_n), .start(start),
    .code_stored(code_stored), .code_fresh(code_fresh),
    .done(done), .status(status), .fix_byte(fix_byte),
    .fix_bit(fix_bit), .fix_mask(fix_mask)
  );

  function automatic exp_t got();
    return '{st: status, byt: fix_byte, bt: fix_bit, msk: fix_mask};
  endfunction

  task automatic compare(input exp_t e, input string tag);
    exp_t g = got();
    checks++;
    if (g !== e) begin
      bad++;
      $display("FAIL %s: got st=%b byte=%0d bit=%0d mask=%h, expected st=%b byte=%0d bit=%0d mask=%h",
               tag, g.st, g.byt, g.bt, g.msk, e.st, e.byt, e.bt, e.msk);
    end
  endtask

  // Independent model: bit-wise rotate by 6, pair scan, odd-bit gather.
  function automatic exp_t model(input logic [23:0] a, input logic [23:0] b);
    logic [23:0] d = a ^ b, p = '0;
    int ones = 0;
    bit full = 1;
    exp_t e = '0;
    for (int j = 0; j < 24; j++) begin
      p[(j < 18) ? j + 6 : j - 18] = d[j];
      if (d[j]) ones++;
    end
    for (int k = 0; k < 12; k++) if (!(p[2*k] || p[2*k+1])) full = 0;
    if (d == 0) e.st = 2'b00;
    else if (full) begin
      e.st = 2'b01;
      for (int k = 0; k < 3; k++) e.bt[k] = p[2*k+1];
      for (int k = 0; k < 9; k++) e.byt[k] = p[2*k+7];
      e.msk = 8'd1 << e.bt;
    end else if (ones == 1) e.st = 2'b10;
    else e.st = 2'b11;
    return e;
  endfunction

  task automatic drive(input logic [23:0] s, input logic [23:0] f, input exp_t e, input string tag);
    @(negedge clk);
    code_stored = s;
    code_fresh  = f;
    start = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Single data-bit error at (addr, bitn): build ordered syndrome, unorder to raw.
  task automatic data_err(input int addr, input int bitn, input string tag);
    logic [23:0] p = '0, raw = '0, f;
    exp_t e;
    for (int k = 0; k < 3; k++) begin p[2*k+1] = bitn[k]; p[2*k] = ~bitn[k]; end
    for (int k = 0; k < 9; k++) begin p[2*k+7] = addr[k]; p[2*k+6] = ~addr[k]; end
    for (int j = 0; j < 24; j++) raw[j] = p[(j < 18) ? j + 6 : j - 18];
    f = 24'($urandom);
    e = '{st: 2'b01, byt: 9'(addr), bt: 3'(bitn), msk: 8'd1 << bitn};
    drive(f ^ raw, f, e, tag);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) begin
        checks++; bad++;
        $display("FAIL R2: done high with nothing pending, got 1 expected 0");
      end else begin
        last_exp = exp_q.pop_front();
        compare(last_exp, tag_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; bad++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [23:0] v;
    repeat (3) @(negedge clk);
    compare('0, "R1 reset outputs");
    checks++;
    if (done !== 1'b0) begin bad++; $display("FAIL R1: done got %b expected 0", done); end
    rst_n = 1'b1;

    // R3: identical codes
    drive(24'h000000, 24'h000000, '0, "R3 zero codes");
    drive(24'hA5C33C, 24'hA5C33C, '0, "R3 equal codes");
    drive(24'hFFFFFF, 24'hFFFFFF, '0, "R3 all-ones codes");

    // R4 R5 R6 R7 R8: single data-bit errors
    data_err(0, 0, "R7 R6 address 0 bit 0");
    data_err(511, 7, "R7 R6 address 511 bit 7");
    data_err(9'h155, 2, "R4 R7 alternating address");
    data_err(9'h0AA, 5, "R4 R8 alternating address");
    for (int b = 0; b < 8; b++) data_err(37 * b + 3, b, "R6 R8 bit index sweep");

    // R5: every pair doubly set still counts as covered
    drive(24'hFFFFFF, 24'h000000, '{st: 2'b01, byt: 9'd511, bt: 3'd7, msk: 8'h80}, "R5 all pairs doubly set");

    // R9: every single check-code bit
    for (int j = 0; j < 24; j++) begin
      v = 24'h3C96E1;
      drive(v ^ (24'd1 << j), v, '{st: 2'b10, byt: '0, bt: '0, msk: '0}, "R9 single code bit");
    end

    // R10: multi-bit differences that miss at least one pair
    drive(24'h000003, 24'h0, model(24'h000003, 24'h0), "R10 two adjacent bits");
    drive(24'hFFFFFC, 24'h0, model(24'hFFFFFC, 24'h0), "R10 one pair empty");
    drive(24'h810042, 24'h0, model(24'h810042, 24'h0), "R10 sparse difference");
    for (int n = 0; n < 6; n++) begin
      v = 24'($urandom);
      drive(v, 24'h5A5A5A, model(v, 24'h5A5A5A), "R10 R5 random difference");
    end

    // R11: last result held while start stays low
    data_err(300, 6, "R11 setup");
    repeat (6) @(negedge clk);
    compare(last_exp, "R11 outputs held idle");
    checks++;
    if (done !== 1'b0) begin bad++; $display("FAIL R2: done got %b expected 0 when idle", done); end

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      bad++;
      $display("FAIL R2: pending results got %0d expected 0", exp_q.size());
    end
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule